// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the reservations that load-linked accesses place on cache lines. It decides whether each store-conditional that completes may succeed. A cache controller reports every completed write-class request on a single completion port, together with the line address, the requester identifier and whether the line's tag is present. The monitor answers each load-linked and store-conditional with a registered success bit one cycle later. A store-conditional succeeds only when its line still carries a reservation owned by the same requester.

Reservations are removed in four cases. Every store-conditional removes the reservation on its line, whatever the outcome. A plain write by the owning requester to a present line removes it. A loss of coherence permission removes it when the controller flags that a store-conditional to the lost line is still pending. Reservations sit in a small table, and a new line arriving when the table is full displaces the entry that was set or refreshed longest ago. Locked read-modify-write completions drive a separate hold flag that asks the controller to stall further requests to that line.

Top module: `llsc_monitor`

## Requirements
- R1: A completion with kind 1 (load-linked) sets a reservation on its line owned by its requester. In the next cycle `rsp_valid` is 1 and `rsp_ok` is 1.
- R2: A completion with kind 2 (store-conditional) gives `rsp_valid`=1 in the next cycle. `rsp_ok` is 1 when a reservation on that line is owned by the same requester, and 0 otherwise.
- R3: Every store-conditional removes the reservation on its line, whether it succeeds or fails and whoever owns it.
- R4: A write-class completion with kind 0 (store), 3 (locked read) or 4 (locked write) removes the reservation on its line only when `cmp_present` is 1 and the reservation is owned by the same requester. Otherwise the reservation is kept.
- R5: When `loss_valid` is 1 and `loss_sc_pend` is 1, the reservation on `loss_line` is removed. When `loss_sc_pend` is 0, the loss has no effect.
- R6: Kind 3 sets `lock_hold` to 1 and `lock_line` to the completion's line from the next cycle on. Kind 4 returns `lock_hold` to 0 from the next cycle on.
- R7: A load-linked to a line and a removal of that same line in the same cycle leave the line reserved by the load-linked requester.
- R8: The table holds ENTRIES lines. A load-linked to a line already in the table only changes the owner and refreshes the entry's age. A load-linked to a new line takes a free entry, or displaces the oldest entry when the table is full. The oldest entry is the one set or refreshed longest ago.
- R9: Idle cycles, store kinds and kinds 5 to 7 give `rsp_valid`=0 in the next cycle. Kinds 5 to 7 leave the reservations and the hold flag unchanged.
- R10: After reset there are no reservations, `rsp_valid` is 0 and `lock_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | A request completion is presented this cycle |
| cmp_kind | input | 3 | Completion kind: 0 store, 1 load-linked, 2 store-conditional, 3 locked read, 4 locked write |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_id | input | ID_W | Requester identifier of the completion |
| cmp_present | input | 1 | The line's tag is present in the cache |
| loss_valid | input | 1 | Coherence permission for a line is lost this cycle |
| loss_line | input | LINE_W | Line that lost permission |
| loss_sc_pend | input | 1 | A store-conditional to the lost line is pending |
| rsp_valid | output | 1 | Response for the completion of the previous cycle |
| rsp_ok | output | 1 | 1 on success, 0 on failure |
| lock_hold | output | 1 | Requests to `lock_line` must be held back |
| lock_line | output | LINE_W | Line under a locked read-modify-write |

## Verification
A load-linked that sets a line can arrive in the same cycle as a permission loss that removes that line. Likewise, a store-conditional or store can remove one line while a loss removes another. The random stream drives the loss port independently of the completion port over a small pool of lines, so these overlaps occur often. A directed case puts a load-linked and a pending-store-conditional loss on the same line together. The outcome is judged afterwards through the ports: a store-conditional by the load-linked requester must succeed, and a bench reference model that applies removals before the set predicts every response.

// File: rtl/llsc_pkg.sv
// Shared encodings for the reservation monitor.
// Assumes the completion kind arrives as a 3-bit code.
package llsc_pkg;
    typedef enum logic [2:0] {
        OP_STORE = 3'd0,
        OP_LL    = 3'd1,
        OP_SC    = 3'd2,
        OP_LKRD  = 3'd3,
        OP_LKWR  = 3'd4
    } op_e;
endpackage

// File: rtl/llsc_lookup.sv
// Compares one line address against every table entry.
// Assumes at most one valid entry per line, so the hit vector is one-hot or zero.
module llsc_lookup #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 26
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][LINE_W-1:0] ent_line,
    input  logic [LINE_W-1:0]              probe_line,
    output logic [ENTRIES-1:0]             hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Per-entry match of a valid entry against the probe.
        assign hit_vec[g] = ent_valid[g] && (ent_line[g] == probe_line);
    end
endmodule

// File: rtl/llsc_age.sv
// Age matrix that names the entry set or refreshed longest ago.
// older[i][j]=1 means entry i was touched before entry j.
// Assumes the victim is used only when every entry is valid.
module llsc_age #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic [ENTRIES-1:0]              cand;

    // Mark the touched entry youngest relative to all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else if (touch_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != int'(touch_idx)) begin
                    older[touch_idx][j] <= 1'b0;
                    older[j][touch_idx] <= 1'b1;
                end
            end
        end
    end

    // An entry is a candidate when it is older than every other valid entry.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            cand[i] = ent_valid[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && ent_valid[j] && !older[i][j]) cand[i] = 1'b0;
            end
        end
    end

    // Pick the lowest-numbered candidate.
    always_comb begin
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/llsc_lock_hold.sv
// Holds the line of an in-flight locked read-modify-write.
// Assumes the locked read and the locked write of a pair arrive in order.
module llsc_lock_hold #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] line_in,
    output logic              hold,
    output logic [LINE_W-1:0] hold_line
);
    // Raise on a locked read, drop on a locked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= 1'b0;
            hold_line <= '0;
        end else if (set_en) begin
            hold      <= 1'b1;
            hold_line <= line_in;
        end else if (clr_en) begin
            hold      <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Reservation monitor for load-linked / store-conditional pairs.
// Keeps a table of (valid, line, owner) entries and answers each load-linked and
// store-conditional one cycle after its completion. Assumes at most one
// completion and one permission loss per cycle. Removals and the set are both
// computed from the state before the edge, and the set wins on a shared line.
module llsc_monitor #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [2:0]        cmp_kind,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic [ID_W-1:0]   cmp_id,
    input  logic              cmp_present,
    input  logic              loss_valid,
    input  logic [LINE_W-1:0] loss_line,
    input  logic              loss_sc_pend,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              lock_hold,
    output logic [LINE_W-1:0] lock_line
);
    import llsc_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             res_valid;
    logic [ENTRIES-1:0][LINE_W-1:0] res_line;
    logic [ENTRIES-1:0][ID_W-1:0]   res_id;

    logic [ENTRIES-1:0] cmp_hit_vec, loss_hit_vec;
    logic [ENTRIES-1:0] clr_vec, set_vec;
    logic               cmp_hit, owner_match;
    logic [IDX_W-1:0]   cmp_idx, free_idx, victim_idx, alloc_idx;
    logic               any_free;
    logic               is_ll, is_sc, is_wr, is_lkrd, is_lkwr;

    llsc_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_cmp_lu (
        .ent_valid (res_valid),
        .ent_line  (res_line),
        .probe_line(cmp_line),
        .hit_vec   (cmp_hit_vec)
    );

    llsc_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_loss_lu (
        .ent_valid (res_valid),
        .ent_line  (res_line),
        .probe_line(loss_line),
        .hit_vec   (loss_hit_vec)
    );

    llsc_age #(.ENTRIES(ENTRIES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (is_ll),
        .touch_idx (alloc_idx),
        .ent_valid (res_valid),
        .victim_idx(victim_idx)
    );

    llsc_lock_hold #(.LINE_W(LINE_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (is_lkrd),
        .clr_en   (is_lkwr),
        .line_in  (cmp_line),
        .hold     (lock_hold),
        .hold_line(lock_line)
    );

    // Decode the completion kind.
    always_comb begin
        is_ll   = cmp_valid && (cmp_kind == OP_LL);
        is_sc   = cmp_valid && (cmp_kind == OP_SC);
        is_lkrd = cmp_valid && (cmp_kind == OP_LKRD);
        is_lkwr = cmp_valid && (cmp_kind == OP_LKWR);
        is_wr   = cmp_valid && (cmp_kind == OP_STORE || cmp_kind == OP_LKRD ||
                                cmp_kind == OP_LKWR);
    end

    // Encode the completion hit and the first free entry.
    always_comb begin
        cmp_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cmp_hit_vec[i]) cmp_idx = IDX_W'(i);
            if (!res_valid[i])  free_idx = IDX_W'(i);
        end
        cmp_hit     = |cmp_hit_vec;
        any_free    = !(&res_valid);
        owner_match = cmp_hit && (res_id[cmp_idx] == cmp_id);
    end

    // Choose the entry a load-linked writes: own line, free slot, or oldest.
    always_comb begin
        if (cmp_hit)       alloc_idx = cmp_idx;
        else if (any_free) alloc_idx = free_idx;
        else               alloc_idx = victim_idx;
    end

    // Gather removals from all sources and the single set.
    always_comb begin
        clr_vec = '0;
        if (is_sc)                              clr_vec = clr_vec | cmp_hit_vec;
        if (is_wr && cmp_present && owner_match) clr_vec = clr_vec | cmp_hit_vec;
        if (loss_valid && loss_sc_pend)         clr_vec = clr_vec | loss_hit_vec;
        set_vec = '0;
        if (is_ll) set_vec[alloc_idx] = 1'b1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Update one entry; a set overrides a removal.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_valid[g] <= 1'b0;
                res_line[g]  <= '0;
                res_id[g]    <= '0;
            end else if (set_vec[g]) begin
                res_valid[g] <= 1'b1;
                res_line[g]  <= cmp_line;
                res_id[g]    <= cmp_id;
            end else if (clr_vec[g]) begin
                res_valid[g] <= 1'b0;
            end
        end
    end

    // Register the response for load-linked and store-conditional.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= is_ll || is_sc;
            rsp_ok    <= is_ll || (is_sc && owner_match);
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Port-level properties of the reservation monitor, bound to every instance.
module llsc_monitor_chk #(
    parameter int LINE_W = 26,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic [2:0]        cmp_kind,
    input logic [LINE_W-1:0] cmp_line,
    input logic [ID_W-1:0]   cmp_id,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              lock_hold,
    input logic [LINE_W-1:0] lock_line
);
    a_r1_ll_always_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd1) |=> (rsp_valid && rsp_ok));

    a_r2_ll_then_sc_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd2 && $past(cmp_valid && cmp_kind == 3'd1) &&
         cmp_line == $past(cmp_line) && cmp_id == $past(cmp_id)) |=> rsp_ok);

    a_r3_sc_twice_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd2 && $past(cmp_valid && cmp_kind == 3'd2) &&
         cmp_line == $past(cmp_line)) |=> (rsp_valid && !rsp_ok));

    a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd3) |=> (lock_hold && lock_line == $past(cmp_line)));

    a_r6_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd4) |=> !lock_hold);

    a_r9_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_valid && (cmp_kind == 3'd1 || cmp_kind == 3'd2)) |=> !rsp_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_valid(cmp_valid),
    .cmp_kind (cmp_kind),
    .cmp_line (cmp_line),
    .cmp_id   (cmp_id),
    .rsp_valid(rsp_valid),
    .rsp_ok   (rsp_ok),
    .lock_hold(lock_hold),
    .lock_line(lock_line)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
    localparam int ENTRIES = 4;
    localparam int LINE_W  = 26;
    localparam int ID_W    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_valid = 1'b0;
    logic [2:0]        cmp_kind = '0;
    logic [LINE_W-1:0] cmp_line = '0;
    logic [ID_W-1:0]   cmp_id = '0;
    logic              cmp_present = 1'b0;
    logic              loss_valid = 1'b0;
    logic [LINE_W-1:0] loss_line = '0;
    logic              loss_sc_pend = 1'b0;
    logic              rsp_valid, rsp_ok, lock_hold;
    logic [LINE_W-1:0] lock_line;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Reference model state.
    bit                m_v[ENTRIES];
    logic [LINE_W-1:0] m_line[ENTRIES];
    logic [ID_W-1:0]   m_id[ENTRIES];
    int                m_stamp[ENTRIES];
    int                stamp_ctr = 0;
    bit                e_hold = 1'b0;
    logic [LINE_W-1:0] e_lline = '0;

    always #2.5 clk = ~clk;

    llsc_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) i_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_line(cmp_line), .cmp_id(cmp_id), .cmp_present(cmp_present),
        .loss_valid(loss_valid), .loss_line(loss_line), .loss_sc_pend(loss_sc_pend),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .lock_hold(lock_hold), .lock_line(lock_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int find(input logic [LINE_W-1:0] ln);
        for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_line[i] == ln) return i;
        return -1;
    endfunction

    // Drive one cycle of stimulus, predict, and check one cycle later.
    task automatic step(input logic v, input logic [2:0] k, input int ln, input int id,
                        input logic pres, input logic lv, input int lln, input logic lp,
                        input string tag);
        int  hit, lhit, a;
        bit  e_rv, e_ok;
        bit  clr[ENTRIES];
        cmp_valid = v; cmp_kind = k; cmp_line = LINE_W'(ln); cmp_id = ID_W'(id);
        cmp_present = pres; loss_valid = lv; loss_line = LINE_W'(lln); loss_sc_pend = lp;
        hit  = find(LINE_W'(ln));
        lhit = find(LINE_W'(lln));
        e_rv = v && (k == 3'd1 || k == 3'd2);
        e_ok = v && (k == 3'd1 || (k == 3'd2 && hit >= 0 && m_id[hit] == ID_W'(id)));
        a = hit;
        if (a < 0) for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) a = i;
        if (a < 0) begin
            a = 0;
            for (int i = 1; i < ENTRIES; i++) if (m_stamp[i] < m_stamp[a]) a = i;
        end
        foreach (clr[i]) clr[i] = 1'b0;
        if (v && k == 3'd2 && hit >= 0) clr[hit] = 1'b1;
        if (v && (k == 3'd0 || k == 3'd3 || k == 3'd4) && pres && hit >= 0 &&
            m_id[hit] == ID_W'(id)) clr[hit] = 1'b1;
        if (lv && lp && lhit >= 0) clr[lhit] = 1'b1;
        for (int i = 0; i < ENTRIES; i++) if (clr[i]) m_v[i] = 1'b0;
        if (v && k == 3'd1) begin
            m_v[a] = 1'b1; m_line[a] = LINE_W'(ln); m_id[a] = ID_W'(id);
            stamp_ctr++; m_stamp[a] = stamp_ctr;
        end
        if (v && k == 3'd3) begin e_hold = 1'b1; e_lline = LINE_W'(ln); end
        if (v && k == 3'd4) e_hold = 1'b0;
        @(negedge clk);
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
        if (e_rv) chk({tag, " rsp_ok"}, 32'(rsp_ok), 32'(e_ok));
        chk({tag, " lock_hold"}, 32'(lock_hold), 32'(e_hold));
        if (e_hold) chk({tag, " lock_line"}, 32'(lock_line), 32'(e_lline));
    endtask

    task automatic idle();
        step(1'b0, 3'd0, 0, 0, 1'b0, 1'b0, 0, 1'b0, "R9 idle");
    endtask

    initial begin
        foreach (m_v[i]) begin m_v[i] = 1'b0; m_stamp[i] = 0; m_line[i] = '0; m_id[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 reset lock_hold", 32'(lock_hold), 32'd0);
        step(1, 3'd2, 5, 1, 1, 0, 0, 0, "R10 sc after reset fails");

        // R1, R2: load-linked then matching store-conditional.
        step(1, 3'd1, 7, 2, 1, 0, 0, 0, "R1 ll");
        step(1, 3'd2, 7, 2, 1, 0, 0, 0, "R2 sc owner ok");
        // R3: failing store-conditional by another requester still clears.
        step(1, 3'd1, 8, 1, 1, 0, 0, 0, "R1 ll");
        step(1, 3'd2, 8, 3, 1, 0, 0, 0, "R3 sc other id fails");
        step(1, 3'd2, 8, 1, 1, 0, 0, 0, "R3 owner sc after clear fails");
        // R4: store rules.
        step(1, 3'd1, 9, 1, 1, 0, 0, 0, "R1 ll");
        step(1, 3'd0, 9, 2, 1, 0, 0, 0, "R4 store other id keeps");
        step(1, 3'd0, 9, 1, 0, 0, 0, 0, "R4 store absent keeps");
        step(1, 3'd2, 9, 1, 1, 0, 0, 0, "R4 reservation kept");
        step(1, 3'd1, 9, 1, 1, 0, 0, 0, "R1 ll");
        step(1, 3'd0, 9, 1, 1, 0, 0, 0, "R4 store owner clears");
        step(1, 3'd2, 9, 1, 1, 0, 0, 0, "R4 sc after own store fails");
        // R5: permission loss.
        step(1, 3'd1, 10, 4, 1, 0, 0, 0, "R1 ll");
        step(0, 3'd0, 0, 0, 0, 1, 10, 0, "R5 loss no pending");
        step(1, 3'd2, 10, 4, 1, 0, 0, 0, "R5 kept without pending");
        step(1, 3'd1, 10, 4, 1, 0, 0, 0, "R1 ll");
        step(0, 3'd0, 0, 0, 0, 1, 10, 1, "R5 loss pending");
        step(1, 3'd2, 10, 4, 1, 0, 0, 0, "R5 cleared by loss");
        // R7: set wins over a same-cycle removal.
        step(1, 3'd1, 11, 5, 1, 1, 11, 1, "R7 ll with loss");
        step(1, 3'd2, 11, 5, 1, 0, 0, 0, "R7 set wins");
        // R6: locked pair.
        step(1, 3'd3, 12, 1, 1, 0, 0, 0, "R6 locked read");
        idle();
        step(1, 3'd4, 12, 1, 1, 0, 0, 0, "R6 locked write");
        // R9: reserved kinds ignored.
        step(1, 3'd1, 13, 2, 1, 0, 0, 0, "R1 ll");
        step(1, 3'd6, 13, 2, 1, 0, 0, 0, "R9 kind 6");
        step(1, 3'd2, 13, 2, 1, 0, 0, 0, "R9 reservation intact");
        // R8: eviction of oldest, refresh on repeat.
        step(1, 3'd1, 20, 1, 1, 0, 0, 0, "R8 fill");
        step(1, 3'd1, 21, 1, 1, 0, 0, 0, "R8 fill");
        step(1, 3'd1, 22, 1, 1, 0, 0, 0, "R8 fill");
        step(1, 3'd1, 23, 1, 1, 0, 0, 0, "R8 fill");
        step(1, 3'd1, 20, 2, 1, 0, 0, 0, "R8 refresh");
        step(1, 3'd1, 24, 1, 1, 0, 0, 0, "R8 evict");
        step(1, 3'd2, 21, 1, 1, 0, 0, 0, "R8 oldest evicted");
        step(1, 3'd2, 20, 2, 1, 0, 0, 0, "R8 refreshed kept");

        // Constrained random mix.
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            logic [2:0] k;
            k = (r < 3) ? 3'd1 : (r < 6) ? 3'd2 : (r < 8) ? 3'd0 : 3'($urandom_range(3, 7));
            step($urandom_range(0, 7) != 0, k, $urandom_range(0, 5), $urandom_range(0, 2),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 5), $urandom_range(0, 1) == 1, "R2 random");
        end
        idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule